// File: doc/BRIEF.md
# PLL and APB Frequency Calculator

This block works out, in whole hertz, the output frequency of a high-speed PLL and the frequency of the peripheral (APB) bus clock derived from it. It takes the PLL parameter word, the strap word, the clock-select word and a one-bit variant select. One start pulse captures all four. After a run of integer steps it raises a one-cycle done strobe, and both 32-bit results are then valid. All arithmetic is unsigned and truncating. Divisions go through one shared restoring divider that produces one quotient bit per cycle.

The reference clock is picked from two strap bits. The PLL word then decides the case: the PLL is off, the PLL is bypassed, the PLL uses register-programmed dividers, or (older variant only) the PLL takes a fixed frequency from a strap-indexed table. The two variants place the divider fields differently and combine them in a different order. The APB frequency is the PLL frequency divided by the prescaler field of the clock-select word plus one, and then by a fixed factor set by the variant.

Top module: `pll_freq_calc`

## Requirements
- R1: Reference clock: strap bit 23 set gives 25,000,000 Hz, whatever bit 18 holds. Otherwise strap bit 18 set gives 48,000,000 Hz. Otherwise it is 24,000,000 Hz.
- R2: When the off bit is set (bit 18 for the older variant, `variant_sel`=0; bit 19 for the newer variant, `variant_sel`=1), `pll_hz` and `apb_hz` are both 0, whatever the bypass and programmed bits hold.
- R3: Older variant with the programmed bit (bit 11) set and the bypass bit (bit 17) clear: n = bits 10:5, od = bit 4, d = bits 3:0. The multiplier is (2 - od) * ((n + 2) / (d + 1)) with truncating division, and `pll_hz` = reference * multiplier.
- R4: Older variant with the programmed bit clear: the 2-bit strap field at bits 9:8 selects 384/360/336/408 MHz (values 0..3) for a 24 or 48 MHz reference, and 400/375/350/425 MHz for a 25 MHz reference. The bypass bit is ignored in this case.
- R5: Newer variant with bypass (bit 20) clear: p = bits 18:13, m = bits 12:5, n = bits 4:0. The multiplier is ((m + 1) / (n + 1)) / (p + 1), each division truncating.
- R6: With bypass set (newer variant; or older variant with the programmed bit set), `pll_hz` equals the reference clock.
- R7: `apb_hz` = (`pll_hz` / (clock-select bits 25:23 + 1)) / 2 for the older variant and / 4 for the newer one, each step truncating.
- R8: A `start` in idle captures all inputs and raises `busy` the next cycle. `done` is a single-cycle pulse, and `busy` is low in that cycle. A `start` while busy is ignored and does not alter the result of the current run.
- R9: The product of reference and multiplier is kept modulo 2^32.
- R10: After reset `pll_hz`, `apb_hz`, `busy` and `done` are 0. The results change only in a `done` cycle and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (taken only when idle) |
| variant_sel | input | 1 | 0 = older field layout, 1 = newer field layout |
| pll_param | input | 32 | PLL parameter word |
| strap_word | input | 32 | Strap word (reference and table select) |
| clk_sel | input | 32 | Clock-select word holding the APB prescaler |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle strobe: results valid |
| pll_hz | output | 32 | PLL output frequency in Hz |
| apb_hz | output | 32 | APB bus frequency in Hz |

## Verification
The hardest case to reach from the ports is a second `start` that arrives part-way through a run, while the shared divider is busy with its first quotient. To create it, the stimulus pulses `start` again a few cycles after launch, with very different parameter and strap words on the inputs. It then checks that the completed result still matches the first operand set and that only one `done` appears. The wrap-around product is reached with the largest older-variant multiplier on a 48 MHz reference. The strap-table path is covered by sweeping every selector value under both reference rows.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  // Field layout of the older variant (positions are part of the behaviour)
  localparam int OLD_N_LSB  = 5;
  localparam int OLD_N_W    = 6;
  localparam int OLD_OD_BIT = 4;
  localparam int OLD_D_LSB  = 0;
  localparam int OLD_D_W    = 4;

  // Field layout of the newer variant
  localparam int NEW_P_LSB  = 13;
  localparam int NEW_P_W    = 6;
  localparam int NEW_M_LSB  = 5;
  localparam int NEW_M_W    = 8;
  localparam int NEW_N_LSB  = 0;
  localparam int NEW_N_W    = 5;

  localparam logic [31:0] REF_24M_HZ = 32'd24_000_000;
  localparam logic [31:0] REF_25M_HZ = 32'd25_000_000;
  localparam logic [31:0] REF_48M_HZ = 32'd48_000_000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_WAIT_A,
    ST_WAIT_B,
    ST_MUL,
    ST_APB,
    ST_WAIT_C
  } calc_state_e;

  // Fixed frequencies used when the older variant is not programmed
  function automatic logic [31:0] strap_table_hz(input logic ref25, input logic [1:0] sel);
    logic [31:0] hz;
    if (ref25) begin
      case (sel)
        2'd0:    hz = 32'd400_000_000;
        2'd1:    hz = 32'd375_000_000;
        2'd2:    hz = 32'd350_000_000;
        default: hz = 32'd425_000_000;
      endcase
    end else begin
      case (sel)
        2'd0:    hz = 32'd384_000_000;
        2'd1:    hz = 32'd360_000_000;
        2'd2:    hz = 32'd336_000_000;
        default: hz = 32'd408_000_000;
      endcase
    end
    return hz;
  endfunction

endpackage

// File: rtl/pll_refclk_sel.sv
module pll_refclk_sel
  import pll_calc_pkg::*;
#(
  parameter int HZ_W = 32
) (
  input  logic            sel_25m,
  input  logic            sel_48m,
  output logic [HZ_W-1:0] ref_hz
);

  always_comb begin
    if (sel_25m) begin
      ref_hz = HZ_W'(REF_25M_HZ);
    end else if (sel_48m) begin
      ref_hz = HZ_W'(REF_48M_HZ);
    end else begin
      ref_hz = HZ_W'(REF_24M_HZ);
    end
  end

endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_n;
  logic [W-1:0]  quo_q, quo_n;
  logic [W-1:0]  dvs_q, dvs_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;

  logic [W:0]    shifted;
  logic          fits;
  logic [W-1:0]  diff;

  assign busy     = (cnt_q != '0);
  assign done     = done_q;
  assign quotient = quo_q;

  assign shifted = {rem_q, quo_q[W-1]};
  assign fits    = (shifted >= {1'b0, dvs_q});
  assign diff    = shifted[W-1:0] - dvs_q;

  always_comb begin
    rem_n  = rem_q;
    quo_n  = quo_q;
    dvs_n  = dvs_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (!busy && start) begin
      rem_n = '0;
      quo_n = dividend;
      dvs_n = divisor;
      cnt_n = CW'(W);
    end else if (busy) begin
      if (fits) begin
        rem_n = diff;
        quo_n = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_n = shifted[W-1:0];
        quo_n = {quo_q[W-2:0], 1'b0};
      end
      cnt_n  = cnt_q - CW'(1);
      done_n = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      dvs_q  <= dvs_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_calc_pkg::*;
#(
  parameter int HZ_W          = 32,
  parameter int REG_W         = 32,
  parameter int OLD_OFF_BIT   = 18,
  parameter int OLD_BYP_BIT   = 17,
  parameter int OLD_PROG_BIT  = 11,
  parameter int NEW_OFF_BIT   = 19,
  parameter int NEW_BYP_BIT   = 20,
  parameter int STRAP_25M_BIT = 23,
  parameter int STRAP_48M_BIT = 18,
  parameter int STRAP_SEL_LSB = 8,
  parameter int PDIV_LSB      = 23,
  parameter int PDIV_W        = 3,
  parameter int OLD_APB_SHIFT = 1,
  parameter int NEW_APB_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             variant_sel,
  input  logic [REG_W-1:0] pll_param,
  input  logic [REG_W-1:0] strap_word,
  input  logic [REG_W-1:0] clk_sel,
  output logic             busy,
  output logic             done,
  output logic [HZ_W-1:0]  pll_hz,
  output logic [HZ_W-1:0]  apb_hz
);

  calc_state_e      state_q, state_n;
  logic             var_q;
  logic [REG_W-1:0] param_q, strap_q, csel_q;
  logic [HZ_W-1:0]  mult_q, mult_n;
  logic [HZ_W-1:0]  acc_q, acc_n;
  logic [HZ_W-1:0]  pll_q, pll_n;
  logic [HZ_W-1:0]  apb_q, apb_n;
  logic             done_q, done_n;
  logic             capture;

  // Divider interface
  logic             div_go;
  logic [HZ_W-1:0]  div_a, div_b;
  logic             div_busy, div_done;
  logic [HZ_W-1:0]  div_q;

  // Decoded fields of the captured words
  logic             pll_off, pll_byp, pll_prog;
  logic [OLD_N_W-1:0] old_n;
  logic             old_od;
  logic [OLD_D_W-1:0] old_d;
  logic [NEW_P_W-1:0] new_p;
  logic [NEW_M_W-1:0] new_m;
  logic [NEW_N_W-1:0] new_n;
  logic [1:0]       tbl_sel;
  logic [PDIV_W-1:0] pdiv;
  logic [HZ_W-1:0]  ref_hz;
  logic [HZ_W-1:0]  product;
  logic [HZ_W-1:0]  old_mult;

  assign pll_off  = var_q ? param_q[NEW_OFF_BIT] : param_q[OLD_OFF_BIT];
  assign pll_byp  = var_q ? param_q[NEW_BYP_BIT] : param_q[OLD_BYP_BIT];
  assign pll_prog = var_q | param_q[OLD_PROG_BIT];

  assign old_n    = param_q[OLD_N_LSB +: OLD_N_W];
  assign old_od   = param_q[OLD_OD_BIT];
  assign old_d    = param_q[OLD_D_LSB +: OLD_D_W];
  assign new_p    = param_q[NEW_P_LSB +: NEW_P_W];
  assign new_m    = param_q[NEW_M_LSB +: NEW_M_W];
  assign new_n    = param_q[NEW_N_LSB +: NEW_N_W];
  assign tbl_sel  = strap_q[STRAP_SEL_LSB +: 2];
  assign pdiv     = csel_q[PDIV_LSB +: PDIV_W];

  pll_refclk_sel #(.HZ_W(HZ_W)) u_refclk (
    .sel_25m (strap_q[STRAP_25M_BIT]),
    .sel_48m (strap_q[STRAP_48M_BIT]),
    .ref_hz  (ref_hz)
  );

  pll_restoring_div #(.W(HZ_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_go),
    .dividend (div_a),
    .divisor  (div_b),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_q)
  );

  // Truncating product (kept modulo 2^HZ_W)
  assign product  = ref_hz * mult_q;
  // (2 - od) times the first quotient
  assign old_mult = old_od ? div_q : {div_q[HZ_W-2:0], 1'b0};

  assign capture = (state_q == ST_IDLE) && start;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign pll_hz  = pll_q;
  assign apb_hz  = apb_q;

  always_comb begin
    state_n = state_q;
    mult_n  = mult_q;
    acc_n   = acc_q;
    pll_n   = pll_q;
    apb_n   = apb_q;
    done_n  = 1'b0;
    div_go  = 1'b0;
    div_a   = '0;
    div_b   = '0;
    case (state_q)
      ST_IDLE: begin
        if (start) state_n = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (pll_off) begin
          acc_n   = '0;
          state_n = ST_APB;
        end else if (!pll_prog) begin
          acc_n   = HZ_W'(strap_table_hz(strap_q[STRAP_25M_BIT], tbl_sel));
          state_n = ST_APB;
        end else if (pll_byp) begin
          mult_n  = HZ_W'(1);
          state_n = ST_MUL;
        end else begin
          div_go  = 1'b1;
          if (var_q) begin
            div_a = HZ_W'(new_m) + HZ_W'(1);
            div_b = HZ_W'(new_n) + HZ_W'(1);
          end else begin
            div_a = HZ_W'(old_n) + HZ_W'(2);
            div_b = HZ_W'(old_d) + HZ_W'(1);
          end
          state_n = ST_WAIT_A;
        end
      end
      ST_WAIT_A: begin
        if (div_done) begin
          if (var_q) begin
            div_go  = 1'b1;
            div_a   = div_q;
            div_b   = HZ_W'(new_p) + HZ_W'(1);
            state_n = ST_WAIT_B;
          end else begin
            mult_n  = old_mult;
            state_n = ST_MUL;
          end
        end
      end
      ST_WAIT_B: begin
        if (div_done) begin
          mult_n  = div_q;
          state_n = ST_MUL;
        end
      end
      ST_MUL: begin
        acc_n   = product;
        state_n = ST_APB;
      end
      ST_APB: begin
        div_go  = 1'b1;
        div_a   = acc_q;
        div_b   = HZ_W'(pdiv) + HZ_W'(1);
        state_n = ST_WAIT_C;
      end
      ST_WAIT_C: begin
        if (div_done) begin
          pll_n   = acc_q;
          apb_n   = var_q ? (div_q >> NEW_APB_SHIFT) : (div_q >> OLD_APB_SHIFT);
          done_n  = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mult_q  <= '0;
      acc_q   <= '0;
      pll_q   <= '0;
      apb_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      mult_q  <= mult_n;
      acc_q   <= acc_n;
      pll_q   <= pll_n;
      apb_q   <= apb_n;
      done_q  <= done_n;
    end
  end

  // Input capture register, enabled only by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      var_q   <= 1'b0;
      param_q <= '0;
      strap_q <= '0;
      csel_q  <= '0;
    end else if (capture) begin
      var_q   <= variant_sel;
      param_q <= pll_param;
      strap_q <= strap_word;
      csel_q  <= clk_sel;
    end
  end

endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk #(
  parameter int HZ_W  = 32,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [HZ_W-1:0]  pll_hz,
  input logic [HZ_W-1:0]  apb_hz,
  input logic             pll_off,
  input logic             var_q,
  input logic [REG_W-1:0] param_q,
  input logic [REG_W-1:0] strap_q,
  input logic [REG_W-1:0] csel_q
);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_inputs_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(param_q) && $stable(strap_q) &&
                               $stable(csel_q) && $stable(var_q)));

  a_r10_pll_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_hz) |-> done);

  a_r10_apb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(apb_hz) |-> done);

  a_r2_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pll_off) |-> (pll_hz == '0 && apb_hz == '0));

  a_r7_apb_le_pll: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (apb_hz <= pll_hz));

endmodule

bind pll_freq_calc pll_freq_calc_chk #(.HZ_W(HZ_W), .REG_W(REG_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .pll_hz  (pll_hz),
  .apb_hz  (apb_hz),
  .pll_off (pll_off),
  .var_q   (var_q),
  .param_q (param_q),
  .strap_q (strap_q),
  .csel_q  (csel_q)
);

// File: tb/pll_freq_calc_tb.sv
module pll_freq_calc_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        variant_sel;
  logic [31:0] pll_param, strap_word, clk_sel;
  logic        busy, done;
  logic [31:0] pll_hz, apb_hz;

  int n_checks = 0;
  int n_fail   = 0;
  int n_push   = 0;
  int n_pop    = 0;
  int cycles   = 0;

  logic [31:0] qp[$];
  logic [31:0] qa[$];
  string       qt[$];
  logic [31:0] last_pll, last_apb;

  pll_freq_calc u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .variant_sel (variant_sel),
    .pll_param   (pll_param),
    .strap_word  (strap_word),
    .clk_sel     (clk_sel),
    .busy        (busy),
    .done        (done),
    .pll_hz      (pll_hz),
    .apb_hz      (apb_hz)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Encoders for the default field positions
  function automatic logic [31:0] enc_old(input int n, input int od, input int d,
                                          input int prog, input int byp, input int off);
    return (32'(off) << 18) | (32'(byp) << 17) | (32'(prog) << 11) |
           (32'(n) << 5) | (32'(od) << 4) | 32'(d);
  endfunction

  function automatic logic [31:0] enc_new(input int p, input int m, input int n,
                                          input int byp, input int off);
    return (32'(off) << 19) | (32'(byp) << 20) | (32'(p) << 13) | (32'(m) << 5) | 32'(n);
  endfunction

  function automatic logic [31:0] enc_strap(input int s25, input int s48, input int sel);
    return (32'(s25) << 23) | (32'(s48) << 18) | (32'(sel) << 8);
  endfunction

  function automatic logic [31:0] enc_csel(input int pdiv);
    return 32'(pdiv) << 23;
  endfunction

  // Behaviour model taken from the requirements
  function automatic longint ref_clk(input logic [31:0] s);
    if (s[23]) return 25000000;
    if (s[18]) return 48000000;
    return 24000000;
  endfunction

  function automatic logic [31:0] model_pll(input logic v, input logic [31:0] w, input logic [31:0] s);
    longint rc, mult;
    longint tbl24[4] = '{384000000, 360000000, 336000000, 408000000};
    longint tbl25[4] = '{400000000, 375000000, 350000000, 425000000};
    rc = ref_clk(s);
    if (!v) begin
      if (w[18]) return 32'd0;
      if (!w[11]) return s[23] ? 32'(tbl25[s[9:8]]) : 32'(tbl24[s[9:8]]);
      if (w[17]) return 32'(rc);
      mult = (2 - longint'(w[4])) * ((longint'(w[10:5]) + 2) / (longint'(w[3:0]) + 1));
    end else begin
      if (w[19]) return 32'd0;
      if (w[20]) return 32'(rc);
      mult = ((longint'(w[12:5]) + 1) / (longint'(w[4:0]) + 1)) / (longint'(w[18:13]) + 1);
    end
    return 32'(rc * mult);
  endfunction

  function automatic logic [31:0] model_apb(input logic v, input logic [31:0] pll, input logic [31:0] c);
    longint t;
    t = longint'(pll) / (longint'(c[25:23]) + 1);
    return v ? 32'(t / 4) : 32'(t / 2);
  endfunction

  // Monitor: pops the scoreboard on each done strobe
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (qp.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R8 unexpected done actual=1 expected=0");
      end else begin
        logic [31:0] ep, ea;
        string t;
        ep = qp.pop_front();
        ea = qa.pop_front();
        t  = qt.pop_front();
        check32({t, " pll_hz"}, pll_hz, ep);
        check32({t, " apb_hz (R7)"}, apb_hz, ea);
        check32("R8 busy low with done", 32'(busy), 32'd0);
        last_pll = pll_hz;
        last_apb = apb_hz;
      end
      n_pop++;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  // Driver: launches one run and pushes its expected result
  task automatic run(input string tag, input logic v, input logic [31:0] w,
                     input logic [31:0] s, input logic [31:0] c, input bit poke);
    logic [31:0] ep;
    @(negedge clk);
    variant_sel = v; pll_param = w; strap_word = s; clk_sel = c; start = 1'b1;
    ep = model_pll(v, w, s);
    qp.push_back(ep);
    qa.push_back(model_apb(v, ep, c));
    qt.push_back(tag);
    n_push++;
    @(negedge clk);
    start = 1'b0;
    check32("R8 busy after start", 32'(busy), 32'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      variant_sel = ~v; pll_param = 32'h0000_07E0; strap_word = enc_strap(0, 1, 3);
      clk_sel = enc_csel(7); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (n_pop == n_push);
    @(negedge clk);
    check32("R8 done single cycle", 32'(done), 32'd0);
    repeat (2) @(negedge clk);
    check32("R10 pll_hz held", pll_hz, last_pll);
    check32("R10 apb_hz held", apb_hz, last_apb);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; variant_sel = 1'b0;
    pll_param = '0; strap_word = '0; clk_sel = '0;
    last_pll = '0; last_apb = '0;
    repeat (3) @(negedge clk);
    check32("R10 reset pll_hz", pll_hz, 32'd0);
    check32("R10 reset apb_hz", apb_hz, 32'd0);
    check32("R10 reset busy", 32'(busy), 32'd0);
    check32("R10 reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reference selection through bypass
    run("R1 R6 ref24 new bypass", 1'b1, enc_new(0, 0, 0, 1, 0), enc_strap(0, 0, 0), enc_csel(0), 0);
    run("R1 R6 ref48 new bypass", 1'b1, enc_new(5, 9, 1, 1, 0), enc_strap(0, 1, 0), enc_csel(1), 0);
    run("R1 R6 ref25 priority", 1'b1, enc_new(0, 0, 0, 1, 0), enc_strap(1, 1, 0), enc_csel(2), 0);
    run("R1 R6 old bypass ref25", 1'b0, enc_old(10, 0, 2, 1, 1, 0), enc_strap(1, 0, 0), enc_csel(3), 0);

    // R2 off overrides everything
    run("R2 old off", 1'b0, enc_old(20, 0, 1, 1, 1, 1), enc_strap(0, 1, 2), enc_csel(0), 0);
    run("R2 new off", 1'b1, enc_new(1, 40, 2, 1, 1), enc_strap(1, 0, 0), enc_csel(4), 0);

    // R3 older programmed formula
    run("R3 old n14 od0 d1", 1'b0, enc_old(14, 0, 1, 1, 0, 0), enc_strap(0, 0, 0), enc_csel(0), 0);
    run("R3 old n7 od1 d3", 1'b0, enc_old(7, 1, 3, 1, 0, 0), enc_strap(1, 0, 0), enc_csel(1), 0);
    run("R3 old n0 od1 d15", 1'b0, enc_old(0, 1, 15, 1, 0, 0), enc_strap(0, 1, 0), enc_csel(5), 0);

    // R4 strap table, every selector on both rows, bypass ignored when unprogrammed
    for (int sel = 0; sel < 4; sel++) begin
      run("R4 table ref24", 1'b0, enc_old(3, 0, 0, 0, 0, 0), enc_strap(0, 0, sel), enc_csel(sel), 0);
      run("R4 table ref25", 1'b0, enc_old(3, 0, 0, 0, 1, 0), enc_strap(1, 0, sel), enc_csel(sel + 1), 0);
    end
    run("R4 table ref48 uses 24 row", 1'b0, enc_old(0, 0, 0, 0, 0, 0), enc_strap(0, 1, 3), enc_csel(0), 0);

    // R5 newer formula
    run("R5 new m95 n3 p0", 1'b1, enc_new(0, 95, 3, 0, 0), enc_strap(0, 0, 0), enc_csel(0), 0);
    run("R5 new m200 n4 p2", 1'b1, enc_new(2, 200, 4, 0, 0), enc_strap(1, 0, 0), enc_csel(3), 0);
    run("R5 new m2 n31 p63", 1'b1, enc_new(63, 2, 31, 0, 0), enc_strap(0, 1, 0), enc_csel(7), 0);
    run("R5 R9 new m255 n0 p0", 1'b1, enc_new(0, 255, 0, 0, 0), enc_strap(0, 1, 0), enc_csel(2), 0);

    // R9 wrap of the product
    run("R9 old wrap n63 od0 d0", 1'b0, enc_old(63, 0, 0, 1, 0, 0), enc_strap(0, 1, 0), enc_csel(0), 0);

    // R7 prescaler sweep
    for (int pd = 0; pd < 8; pd++) begin
      run("R7 old pdiv sweep", 1'b0, enc_old(30, 0, 0, 1, 0, 0), enc_strap(0, 0, 0), enc_csel(pd), 0);
      run("R7 new pdiv sweep", 1'b1, enc_new(1, 99, 0, 0, 0), enc_strap(1, 0, 0), enc_csel(pd), 0);
    end

    // R8 start while busy is ignored
    run("R8 poke during old run", 1'b0, enc_old(22, 1, 1, 1, 0, 0), enc_strap(1, 0, 0), enc_csel(1), 1);
    run("R8 poke during new run", 1'b1, enc_new(1, 120, 2, 0, 0), enc_strap(0, 0, 0), enc_csel(6), 1);

    repeat (5) @(negedge clk);
    check32("R8 queue drained", 32'(qp.size()), 32'd0);
    check32("R8 idle at end", 32'(busy), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule